// File: doc/BRIEF.md
# Timer/counter with shared prescaler

This block is an 8-bit count register for a small processor core. Software can read and load it at any time. It advances on one of two kinds of event. The first kind is a one-cycle tick strobe from the core's instruction sequencer. The second kind is a chosen edge of an external count pin. That pin is synchronized into the system clock domain before its edges are detected.

A programmable prescaler always sits between the event source and the counter. The counter therefore steps once per 2, 4, 8 and so on up to 256 events. The prescaler's running count is hidden from software. The only thing that clears it is a software load of the counter.

When the counter wraps from 0xFF to 0x00 it sets a sticky overflow flag. The flag is meant to drive an interrupt request, and it stays set until software clears it. The core writes a small control register to choose the source, the edge and the divide ratio.

Top module: `tick_counter_top`

## Requirements
- R1: While reset is asserted, the count output, the control readback and the overflow flag read 0, and the prescaler's hidden count is 0.
- R2: With control bit 0 at 0 (internal source), the counter counts `tick_i` strobes. Activity on `ext_pin_i` has no effect.
- R3: With control bit 0 at 1 (external source), the counter counts edges of `ext_pin_i`. `tick_i` has no effect. Each pin edge produces exactly one prescaler event.
- R4: Control bit 1 selects the counted pin edge: 0 counts rising edges, 1 counts falling edges. The opposite edge has no effect.
- R5: Control bits [4:2] hold a value k. The counter then advances once per 2^(k+1) source events, so k=0 gives 1:2 and k=7 gives 1:256.
- R6: A pulse on `cnt_wr_i` loads `wdata_i` into the counter. The new value shows on `cnt_o` after the next clock edge. `cnt_o` always shows the current count.
- R7: Loading the counter discards any partial prescaler count. Writing the control register does not clear the prescaler.
- R8: When a counter load and a counter increment fall in the same cycle, the load wins and the counter does not advance in that cycle.
- R9: An increment from 0xFF to 0x00 sets `ovf_o`. The flag stays set until `ovf_clr_i` is pulsed, and loading the counter leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R10: A pulse on `ctl_wr_i` stores `wdata_i[4:0]`. `ctl_o` reads those bits back, with bits [7:5] reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| tick_i | input | 1 | One-cycle instruction-cycle strobe |
| ext_pin_i | input | 1 | Asynchronous external count pin |
| cnt_wr_i | input | 1 | Load counter from wdata_i |
| ctl_wr_i | input | 1 | Load control register from wdata_i |
| wdata_i | input | 8 | Write data |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| cnt_o | output | 8 | Current counter value |
| ctl_o | output | 8 | Control register readback |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The bench sends a partial prescaler count across a counter load. If the design kept that residue, the count would step early after the load. The bench also confirms that rewriting the control register keeps the residue, so a design that cleared on any register write would step late.

A load is made to coincide with a terminal prescaler event. A design that let the increment win would show the loaded value plus one. The bench also exercises both the 1:2 and the 1:256 extremes of the ratio field, which exposes a mask that is off by one position.

Edge polarity is checked by sending lone edges of the unselected kind. The overflow flag is checked through wrap, counter load, clear and a wrap that coincides with a clear. A design that gave the clear priority would lose the overflow event.

// File: rtl/tick_pkg.sv
package tick_pkg;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned PS_W  = 3;
  localparam int unsigned PCW   = 2 ** PS_W;

  typedef struct packed {
    logic [PS_W-1:0] ratio;
    logic            fall_sel;
    logic            src_ext;
  } tick_ctl_t;

  localparam int unsigned CTL_W = $bits(tick_ctl_t);
endpackage

// File: rtl/tick_edge_sync.sv
module tick_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise_o = sync_q & ~prev_q;
  assign fall_o = ~sync_q & prev_q;

  AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_o || fall_o) |=> !(rise_o || fall_o)) else $error("edge lasted two cycles"); // R3
endmodule

// File: rtl/tick_prescale.sv
module tick_prescale #(
  parameter int unsigned PS_W = tick_pkg::PS_W,
  parameter int unsigned PCW  = tick_pkg::PCW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            evt_i,
  input  logic            clr_i,
  input  logic [PS_W-1:0] ratio_i,
  output logic            carry_o
);
  logic [PCW-1:0] pcnt_q, pcnt_d, mask;
  logic           pcnt_en;

  assign mask    = ~({PCW{1'b1}} << ({1'b0, ratio_i} + (PS_W+1)'(1)));
  assign carry_o = evt_i && !clr_i && ((pcnt_q & mask) == mask);
  assign pcnt_en = evt_i || clr_i;

  always_comb begin
    pcnt_d = pcnt_q;
    if (clr_i)      pcnt_d = '0;
    else if (evt_i) pcnt_d = pcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pcnt_q <= '0;
    else if (pcnt_en) pcnt_q <= pcnt_d;
  end

  AST_PS_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pcnt_q == '0)) else $error("prescaler not cleared"); // R7
  AST_PS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_i && !clr_i) |=> $stable(pcnt_q)) else $error("prescaler moved"); // R7
endmodule

// File: rtl/tick_counter_top.sv
module tick_counter_top
  import tick_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ext_pin_i,
  input  logic             cnt_wr_i,
  input  logic             ctl_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] ctl_o,
  output logic             ovf_o
);
  tick_ctl_t        ctl_q, ctl_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             rise, fall, ext_evt, src_evt, carry, wrap;

  tick_edge_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  assign ext_evt = ctl_q.fall_sel ? fall : rise;
  assign src_evt = ctl_q.src_ext ? ext_evt : tick_i;

  tick_prescale #(.PS_W(PS_W), .PCW(PCW)) u_ps (
    .clk     (clk),
    .rst_n   (rst_n),
    .evt_i   (src_evt),
    .clr_i   (cnt_wr_i),
    .ratio_i (ctl_q.ratio),
    .carry_o (carry)
  );

  assign wrap = carry && (cnt_q == {CNT_W{1'b1}});

  always_comb begin
    ctl_d = ctl_q;
    if (ctl_wr_i) ctl_d = tick_ctl_t'(wdata_i[CTL_W-1:0]);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_wr_i)   cnt_d = wdata_i;
    else if (carry) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    ovf_d = ovf_q;
    if (wrap)           ovf_d = 1'b1;
    else if (ovf_clr_i) ovf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (ctl_wr_i)           ctl_q <= ctl_d;
      if (cnt_wr_i || carry)  cnt_q <= cnt_d;
      if (wrap || ovf_clr_i)  ovf_q <= ovf_d;
    end
  end

  assign cnt_o = cnt_q;
  assign ctl_o = {{(CNT_W-CTL_W){1'b0}}, ctl_q};
  assign ovf_o = ovf_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_i |=> (cnt_o == $past(wdata_i))) else $error("load lost"); // R8
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr_i && !src_evt) |=> $stable(cnt_o)) else $error("count moved without event"); // R6
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (carry && cnt_o == {CNT_W{1'b1}}) |=> ovf_o) else $error("wrap missed"); // R9
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o) else $error("flag dropped"); // R9
endmodule

// File: tb/tick_counter_top_tb_top.sv
module tick_counter_top_tb_top;
  logic       clk = 1'b0;
  logic       rst_n, tick, pin, cnt_wr, ctl_wr, ovf_clr;
  logic [7:0] wdata, cnt, ctl;
  logic       ovf;
  int         errors = 0;
  int         checks = 0;

  always #2.5 clk = ~clk;

  tick_counter_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ext_pin_i(pin),
    .cnt_wr_i(cnt_wr), .ctl_wr_i(ctl_wr), .wdata_i(wdata),
    .ovf_clr_i(ovf_clr), .cnt_o(cnt), .ctl_o(ctl), .ovf_o(ovf)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cnt(input logic [7:0] v);
    @(negedge clk); cnt_wr = 1'b1; wdata = v;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wr = 1'b1; wdata = v;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic pin_set(input logic v);
    @(negedge clk); pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      pin_set(1'b1);
      pin_set(1'b0);
    end
  endtask

  task automatic t_reset();
    chk("R1 count", cnt, 8'h00);
    chk("R1 ctl", ctl, 8'h00);
    chk("R1 ovf", {7'b0, ovf}, 8'h00);
    ticks(1);
    chk("R1 prescaler empty after reset", cnt, 8'h00);
    ticks(1);
    chk("R1 first step after two ticks", cnt, 8'h01);
  endtask

  task automatic t_ctl_readback();
    wr_ctl(8'hFF);
    chk("R10 upper bits zero", ctl, 8'h1F);
    wr_ctl(8'h0A);
    chk("R10 readback", ctl, 8'h0A);
  endtask

  task automatic t_internal();
    wr_ctl(8'h00);
    wr_cnt(8'h00);
    ticks(4);
    chk("R2 internal 4 ticks", cnt, 8'h02);
    pulses(3);
    chk("R2 pin ignored", cnt, 8'h02);
  endtask

  task automatic t_ratio();
    wr_ctl(8'h08);
    wr_cnt(8'h00);
    ticks(7);
    chk("R5 1:8 before", cnt, 8'h00);
    ticks(1);
    chk("R5 1:8 step", cnt, 8'h01);
    wr_ctl(8'h1C);
    wr_cnt(8'h00);
    ticks(255);
    chk("R5 1:256 before", cnt, 8'h00);
    ticks(1);
    chk("R5 1:256 step", cnt, 8'h01);
  endtask

  task automatic t_external();
    wr_ctl(8'h01);
    wr_cnt(8'h00);
    pulses(4);
    chk("R3 four rising edges", cnt, 8'h02);
    ticks(10);
    chk("R3 tick ignored", cnt, 8'h02);
  endtask

  task automatic t_falling();
    wr_ctl(8'h03);
    wr_cnt(8'h00);
    pulses(1);
    pin_set(1'b1);
    chk("R4 rising ignored in falling mode", cnt, 8'h00);
    pin_set(1'b0);
    chk("R4 second falling edge steps", cnt, 8'h01);
    wr_ctl(8'h01);
    wr_cnt(8'h00);
    pin_set(1'b1);
    pin_set(1'b0);
    chk("R4 falling ignored in rising mode", cnt, 8'h00);
    pin_set(1'b1);
    chk("R4 second rising edge steps", cnt, 8'h01);
    pin_set(1'b0);
  endtask

  task automatic t_ps_clear();
    wr_ctl(8'h04);
    wr_cnt(8'h00);
    ticks(3);
    wr_cnt(8'h10);
    ticks(3);
    chk("R7 residue discarded", cnt, 8'h10);
    ticks(1);
    chk("R7 step after full ratio", cnt, 8'h11);
    ticks(2);
    wr_ctl(8'h04);
    ticks(2);
    chk("R7 ctl write keeps residue", cnt, 8'h12);
  endtask

  task automatic t_priority();
    wr_ctl(8'h00);
    wr_cnt(8'h00);
    ticks(1);
    @(negedge clk); tick = 1'b1; cnt_wr = 1'b1; wdata = 8'h40;
    @(negedge clk); tick = 1'b0; cnt_wr = 1'b0;
    chk("R8 load wins", cnt, 8'h40);
    ticks(1);
    chk("R8 prescaler cleared by load", cnt, 8'h40);
    ticks(1);
    chk("R6 count after load", cnt, 8'h41);
  endtask

  task automatic t_overflow();
    wr_ctl(8'h00);
    wr_cnt(8'hFE);
    ticks(2);
    chk("R9 FF no flag", {ovf, cnt[6:0]}, 8'h7F);
    ticks(2);
    chk("R9 wrap count", cnt, 8'h00);
    chk("R9 flag set", {7'b0, ovf}, 8'h01);
    wr_cnt(8'h05);
    chk("R9 load keeps flag", {7'b0, ovf}, 8'h01);
    chk("R6 load value", cnt, 8'h05);
    @(negedge clk); ovf_clr = 1'b1;
    @(negedge clk); ovf_clr = 1'b0;
    chk("R9 clear", {7'b0, ovf}, 8'h00);
    wr_cnt(8'hFF);
    ticks(1);
    @(negedge clk); tick = 1'b1; ovf_clr = 1'b1;
    @(negedge clk); tick = 1'b0; ovf_clr = 1'b0;
    chk("R9 wrap beats clear", {7'b0, ovf}, 8'h01);
    chk("R9 wrap with clear count", cnt, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; pin = 1'b0; cnt_wr = 1'b0;
    ctl_wr = 1'b0; ovf_clr = 1'b0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 in reset", cnt, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctl_readback();
    t_internal();
    t_ratio();
    t_external();
    t_falling();
    t_ps_clear();
    t_priority();
    t_overflow();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule